// File: doc/BRIEF.md
# Planar Latch Read/Write Datapath

This block sits between a byte-wide host port and a video memory organised as four byte planes, where each memory address holds one 32-bit word with one byte per plane. A host read fetches the whole word into a 32-bit latch. The host then gets back either a single plane's byte or a colour-compare result that summarises all four planes. A host write builds a full 32-bit word and sends it to memory together with a per-plane enable mask.

The word is built from the host byte, the set/reset colour and the latch. Four write modes decide how these are combined. The steps used are rotation, set/reset substitution, a logic function against the latch, and a bit mask that keeps latch bits.

All mode and colour settings arrive as static configuration inputs. The memory is an external synchronous 32-bit port with one cycle of read latency. The block drops its ready output for the single fill cycle of a read, so a following write always sees the refreshed latch.

Top module: `plane_latch_path`

## Requirements
- R1: After reset, `hostReady` is 1, `hostRvalid` is 0 and the latch holds zero, so a latch-copy write (mode 1) issued first stores 0x00 in every enabled plane.
- R2: Every accepted host read loads the full 32-bit word at `hostAddr` into the latch, and later writes use it.
- R3: Read mode 0 (`cfgReadMode`=0) returns the byte of the plane selected by `cfgReadPlane`. Plane p occupies bits 8p+7..8p of the memory word.
- R4: Read mode 1 (`cfgReadMode`=1) returns the inverse of the OR over all planes of ((plane byte XOR {8{cfgCmpColor[p]}}) AND {8{cfgCmpCare[p]}}).
- R5: Write mode 0 (`cfgWriteMode`=0) rotates the host byte right by `cfgRotate` and gives it to every plane. Each plane p with `cfgSrEnable[p]`=1 instead takes {8{cfgSrValue[p]}}.
- R6: Write mode 1 writes the latch back unchanged, whatever the values of `cfgAluFunc` and `cfgBitMask`.
- R7: Write mode 2 gives plane p the data {8{hostWdata[p]}} and uses `cfgBitMask` as the bit mask.
- R8: Write mode 3 gives plane p the data {8{cfgSrValue[p]}} and uses (rotated host byte AND `cfgBitMask`) as the bit mask.
- R9: In modes 0, 2 and 3 the data is combined with the latch byte by `cfgAluFunc`: 0 passes it through, 1 ANDs it, 2 ORs it and 3 XORs it.
- R10: In modes 0, 2 and 3 every bit whose effective mask bit is 0 is written with the latch bit, and every bit whose mask bit is 1 is written with the logic-function result.
- R11: A write changes only the planes p with `cfgPlaneMask[p]`=1. The other planes of the memory word keep their contents.
- R12: A read accepted in cycle T has `hostReady`=0 in cycle T+1 and `hostRvalid`=1 with the result in cycle T+2, for exactly one cycle. Writes keep `hostReady` high and are issued to memory in the cycle they are accepted. Configuration must be held stable until the result is returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostReq | input | 1 | Host access request |
| hostWe | input | 1 | 1 = write, 0 = read |
| hostAddr | input | ADDR_W | Word address |
| hostWdata | input | PLANE_W | Host write byte |
| hostReady | output | 1 | Request can be accepted this cycle |
| hostRvalid | output | 1 | Read result valid |
| hostRdata | output | PLANE_W | Read result byte |
| cfgReadMode | input | 1 | Read mode select |
| cfgReadPlane | input | SEL_W | Plane returned in read mode 0 |
| cfgWriteMode | input | 2 | Write mode 0..3 |
| cfgRotate | input | ROT_W | Right-rotate count |
| cfgAluFunc | input | 2 | Logic function against latch |
| cfgSrValue | input | PLANES | Set/reset colour, one bit per plane |
| cfgSrEnable | input | PLANES | Set/reset enable per plane (mode 0) |
| cfgCmpColor | input | PLANES | Compare colour (read mode 1) |
| cfgCmpCare | input | PLANES | Compare care mask (read mode 1) |
| cfgBitMask | input | PLANE_W | Bit mask |
| cfgPlaneMask | input | PLANES | Per-plane write enable |
| memAddr | output | ADDR_W | Memory word address |
| memRe | output | 1 | Memory read strobe |
| memWe | output | 1 | Memory write strobe |
| memWdata | output | WORD_W | Memory write word |
| memWmask | output | PLANES | Memory per-plane byte enable |
| memRdata | input | WORD_W | Memory read word, one cycle after memRe |

## Verification
The bench covers several edge cases.

- Latch-copy writes right after reset and right after a read. A design that loaded the latch late, or only partly, would copy stale planes.
- Rotation counts of 0 and 7, and set/reset applied to a subset of planes. An off-by-one rotate or a per-plane select swapped with the enable would corrupt single bits.
- A compare where every plane matches, which must return 0xFF, and a care mask of zero. A missing inversion or a missing care gating shows up at once.
- Long mixed sequences with a zero bit mask and partial plane masks. A design that ignored the mask would overwrite latch bits, or planes that should have stayed unchanged.

// File: rtl/plane_pkg.sv
package plane_pkg;

  typedef enum logic [1:0] {
    WM_ROTATE = 2'd0,
    WM_LATCH  = 2'd1,
    WM_EXPAND = 2'd2,
    WM_SRMASK = 2'd3
  } writeMode_e;

  typedef enum logic [1:0] {
    ALU_PASS = 2'd0,
    ALU_AND  = 2'd1,
    ALU_OR   = 2'd2,
    ALU_XOR  = 2'd3
  } aluFunc_e;

  typedef struct packed {
    logic memRead;
    logic memWrite;
    logic latchLoad;
  } ctrlStrobes_t;

endpackage

// File: rtl/plane_ctrl.sv
module plane_ctrl
  import plane_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         hostReq,
  input  logic         hostWe,
  output logic         hostReady,
  output logic         hostRvalid,
  output ctrlStrobes_t strobes
);

  logic fillPending;
  logic rvalidQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fillPending <= 1'b0;
      rvalidQ     <= 1'b0;
    end else begin
      fillPending <= hostReq && !hostWe && !fillPending;
      rvalidQ     <= fillPending;
    end
  end

  always_comb begin
    strobes           = '0;
    strobes.memRead   = hostReq && !hostWe && !fillPending;
    strobes.memWrite  = hostReq && hostWe && !fillPending;
    strobes.latchLoad = fillPending;
  end

  assign hostReady  = !fillPending;
  assign hostRvalid = rvalidQ;

endmodule

// File: rtl/plane_lane.sv
module plane_lane
  import plane_pkg::*;
#(
  parameter int PLANE_W = 8
) (
  input  logic [PLANE_W-1:0] latchByte,
  input  logic [PLANE_W-1:0] fillByte,
  input  logic [PLANE_W-1:0] rotByte,
  input  logic               hostBit,
  input  logic               srBit,
  input  logic               srEnBit,
  input  logic               cmpBit,
  input  logic               careBit,
  input  logic [1:0]         writeMode,
  input  logic [1:0]         aluFunc,
  input  logic [PLANE_W-1:0] bitMask,
  output logic [PLANE_W-1:0] wrByte,
  output logic [PLANE_W-1:0] diffByte
);

  logic [PLANE_W-1:0] srcByte;
  logic [PLANE_W-1:0] effMask;
  logic [PLANE_W-1:0] aluByte;

  always_comb begin
    unique case (writeMode_e'(writeMode))
      WM_ROTATE: srcByte = srEnBit ? {PLANE_W{srBit}} : rotByte;
      WM_EXPAND: srcByte = {PLANE_W{hostBit}};
      WM_SRMASK: srcByte = {PLANE_W{srBit}};
      default:   srcByte = latchByte;
    endcase
  end

  assign effMask = (writeMode == WM_SRMASK) ? (bitMask & rotByte) : bitMask;

  always_comb begin
    unique case (aluFunc_e'(aluFunc))
      ALU_AND: aluByte = srcByte & latchByte;
      ALU_OR:  aluByte = srcByte | latchByte;
      ALU_XOR: aluByte = srcByte ^ latchByte;
      default: aluByte = srcByte;
    endcase
  end

  always_comb begin
    if (writeMode == WM_LATCH) wrByte = latchByte;
    else wrByte = (aluByte & effMask) | (latchByte & ~effMask);
  end

  assign diffByte = (fillByte ^ {PLANE_W{cmpBit}}) & {PLANE_W{careBit}};

endmodule

// File: rtl/plane_data.sv
module plane_data
  import plane_pkg::*;
#(
  parameter int PLANE_W = 8,
  parameter int PLANES  = 4,
  localparam int WORD_W = PLANE_W * PLANES,
  localparam int ROT_W  = $clog2(PLANE_W),
  localparam int SEL_W  = $clog2(PLANES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       strobes,
  input  logic [PLANE_W-1:0] hostWdata,
  input  logic               cfgReadMode,
  input  logic [SEL_W-1:0]   cfgReadPlane,
  input  logic [1:0]         cfgWriteMode,
  input  logic [ROT_W-1:0]   cfgRotate,
  input  logic [1:0]         cfgAluFunc,
  input  logic [PLANES-1:0]  cfgSrValue,
  input  logic [PLANES-1:0]  cfgSrEnable,
  input  logic [PLANES-1:0]  cfgCmpColor,
  input  logic [PLANES-1:0]  cfgCmpCare,
  input  logic [PLANE_W-1:0] cfgBitMask,
  input  logic [WORD_W-1:0]  memRdata,
  output logic [WORD_W-1:0]  memWdata,
  output logic [WORD_W-1:0]  latchWord,
  output logic [PLANE_W-1:0] hostRdata
);

  logic [WORD_W-1:0]               latchQ;
  logic [PLANE_W-1:0]              rdataQ;
  logic [2*PLANE_W-1:0]            rotWide;
  logic [PLANE_W-1:0]              rotByte;
  logic [PLANES-1:0][PLANE_W-1:0]  diffBytes;
  logic [PLANE_W-1:0]              diffAny;
  logic [PLANE_W-1:0]              readByte;

  assign rotWide = {hostWdata, hostWdata} >> cfgRotate;
  assign rotByte = rotWide[PLANE_W-1:0];

  for (genvar p = 0; p < PLANES; p++) begin : g_lane
    plane_lane #(.PLANE_W(PLANE_W)) uLane (
      .latchByte (latchQ[p*PLANE_W +: PLANE_W]),
      .fillByte  (memRdata[p*PLANE_W +: PLANE_W]),
      .rotByte   (rotByte),
      .hostBit   (hostWdata[p]),
      .srBit     (cfgSrValue[p]),
      .srEnBit   (cfgSrEnable[p]),
      .cmpBit    (cfgCmpColor[p]),
      .careBit   (cfgCmpCare[p]),
      .writeMode (cfgWriteMode),
      .aluFunc   (cfgAluFunc),
      .bitMask   (cfgBitMask),
      .wrByte    (memWdata[p*PLANE_W +: PLANE_W]),
      .diffByte  (diffBytes[p])
    );
  end

  always_comb begin
    diffAny = '0;
    for (int p = 0; p < PLANES; p++) diffAny = diffAny | diffBytes[p];
  end

  always_comb begin
    if (cfgReadMode) readByte = ~diffAny;
    else readByte = memRdata[cfgReadPlane*PLANE_W +: PLANE_W];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      latchQ <= '0;
      rdataQ <= '0;
    end else if (strobes.latchLoad) begin
      latchQ <= memRdata;
      rdataQ <= readByte;
    end
  end

  assign latchWord = latchQ;
  assign hostRdata = rdataQ;

endmodule

// File: rtl/plane_latch_path.sv
module plane_latch_path
  import plane_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int PLANE_W = 8,
  parameter int PLANES  = 4,
  localparam int WORD_W = PLANE_W * PLANES,
  localparam int ROT_W  = $clog2(PLANE_W),
  localparam int SEL_W  = $clog2(PLANES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hostReq,
  input  logic               hostWe,
  input  logic [ADDR_W-1:0]  hostAddr,
  input  logic [PLANE_W-1:0] hostWdata,
  output logic               hostReady,
  output logic               hostRvalid,
  output logic [PLANE_W-1:0] hostRdata,
  input  logic               cfgReadMode,
  input  logic [SEL_W-1:0]   cfgReadPlane,
  input  logic [1:0]         cfgWriteMode,
  input  logic [ROT_W-1:0]   cfgRotate,
  input  logic [1:0]         cfgAluFunc,
  input  logic [PLANES-1:0]  cfgSrValue,
  input  logic [PLANES-1:0]  cfgSrEnable,
  input  logic [PLANES-1:0]  cfgCmpColor,
  input  logic [PLANES-1:0]  cfgCmpCare,
  input  logic [PLANE_W-1:0] cfgBitMask,
  input  logic [PLANES-1:0]  cfgPlaneMask,
  output logic [ADDR_W-1:0]  memAddr,
  output logic               memRe,
  output logic               memWe,
  output logic [WORD_W-1:0]  memWdata,
  output logic [PLANES-1:0]  memWmask,
  input  logic [WORD_W-1:0]  memRdata
);

  ctrlStrobes_t      strobes;
  logic [WORD_W-1:0] latchWord;

  plane_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .hostReq    (hostReq),
    .hostWe     (hostWe),
    .hostReady  (hostReady),
    .hostRvalid (hostRvalid),
    .strobes    (strobes)
  );

  plane_data #(.PLANE_W(PLANE_W), .PLANES(PLANES)) uData (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .hostWdata    (hostWdata),
    .cfgReadMode  (cfgReadMode),
    .cfgReadPlane (cfgReadPlane),
    .cfgWriteMode (cfgWriteMode),
    .cfgRotate    (cfgRotate),
    .cfgAluFunc   (cfgAluFunc),
    .cfgSrValue   (cfgSrValue),
    .cfgSrEnable  (cfgSrEnable),
    .cfgCmpColor  (cfgCmpColor),
    .cfgCmpCare   (cfgCmpCare),
    .cfgBitMask   (cfgBitMask),
    .memRdata     (memRdata),
    .memWdata     (memWdata),
    .latchWord    (latchWord),
    .hostRdata    (hostRdata)
  );

  assign memAddr  = hostAddr;
  assign memRe    = strobes.memRead;
  assign memWe    = strobes.memWrite;
  assign memWmask = strobes.memWrite ? cfgPlaneMask : '0;

endmodule

// File: rtl/plane_latch_path_chk.sv
module plane_latch_path_chk #(
  parameter int PLANE_W = 8,
  parameter int PLANES  = 4,
  localparam int WORD_W = PLANE_W * PLANES
) (
  input logic               clk,
  input logic               rstN,
  input logic               hostReq,
  input logic               hostWe,
  input logic               hostReady,
  input logic               hostRvalid,
  input logic               memRe,
  input logic               memWe,
  input logic [WORD_W-1:0]  memWdata,
  input logic [WORD_W-1:0]  memRdata,
  input logic [1:0]         cfgWriteMode,
  input logic [PLANE_W-1:0] cfgBitMask,
  input logic [WORD_W-1:0]  latchWord
);

  AST_READ_STALLS: assert property (@(posedge clk) disable iff (!rstN)
    (hostReq && !hostWe && hostReady) |=> !hostReady); // R12

  AST_RVALID_AFTER_FILL: assert property (@(posedge clk) disable iff (!rstN)
    hostRvalid |-> $past(!hostReady)); // R12

  AST_RVALID_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    hostRvalid |=> !hostRvalid); // R12

  AST_NO_RW_OVERLAP: assert property (@(posedge clk) disable iff (!rstN)
    !(memRe && memWe)); // R12

  AST_LATCH_FILLED: assert property (@(posedge clk) disable iff (!rstN)
    hostRvalid |-> latchWord == $past(memRdata)); // R2

  AST_LATCH_COPY: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && cfgWriteMode == 2'd1) |-> memWdata == latchWord); // R6

  AST_ZERO_MASK_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && cfgWriteMode != 2'd1 && cfgBitMask == '0) |-> memWdata == latchWord); // R10

endmodule

bind plane_latch_path plane_latch_path_chk #(.PLANE_W(PLANE_W), .PLANES(PLANES)) uChk (.*);

// File: tb/sim_plane_latch_path.sv
`timescale 1ns/1ps
module sim_plane_latch_path;

  localparam int AW = 6;
  localparam int DEPTH = 1 << AW;

  logic clk = 0;
  logic rstN = 0;
  logic hostReq = 0, hostWe = 0;
  logic [AW-1:0] hostAddr = '0;
  logic [7:0] hostWdata = '0;
  logic hostReady, hostRvalid;
  logic [7:0] hostRdata;
  logic cfgReadMode = 0;
  logic [1:0] cfgReadPlane = 0, cfgWriteMode = 0, cfgAluFunc = 0;
  logic [2:0] cfgRotate = 0;
  logic [3:0] cfgSrValue = 0, cfgSrEnable = 0, cfgCmpColor = 0, cfgCmpCare = 0;
  logic [3:0] cfgPlaneMask = 4'hF;
  logic [7:0] cfgBitMask = 8'hFF;
  logic [AW-1:0] memAddr;
  logic memRe, memWe;
  logic [31:0] memWdata;
  logic [3:0] memWmask;
  logic [31:0] memRdata;

  logic [31:0] mem [DEPTH];
  logic [31:0] refMem [DEPTH];
  logic [31:0] refLatch;
  int checks = 0, fails = 0, cyc = 0;
  int unsigned seed = 32'h1234_5678;

  always #4 clk = ~clk;

  plane_latch_path #(.ADDR_W(AW)) u0 (.*);

  function automatic logic [31:0] seedWord(int i);
    return (i * 32'h9E37_79B1) ^ 32'h5A3C_C3A5;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= seedWord(i);
      memRdata <= '0;
    end else begin
      if (memRe) memRdata <= mem[memAddr];
      if (memWe)
        for (int p = 0; p < 4; p++)
          if (memWmask[p]) mem[memAddr][p*8 +: 8] <= memWdata[p*8 +: 8];
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int nextRand();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return int'(seed & 32'h7FFF_FFFF);
  endfunction

  function automatic int rotr(int b, int n);
    int r;
    r = b;
    for (int i = 0; i < n; i++) r = ((r >> 1) | ((r & 1) << 7)) & 255;
    return r;
  endfunction

  function automatic logic [31:0] modelWord(logic [31:0] lat, int d);
    logic [31:0] w;
    int rb, src, msk, lb, res, outb;
    rb = rotr(d, int'(cfgRotate));
    w = '0;
    for (int p = 0; p < 4; p++) begin
      lb = int'(lat[p*8 +: 8]);
      msk = int'(cfgBitMask);
      case (int'(cfgWriteMode))
        0: src = cfgSrEnable[p] ? (cfgSrValue[p] ? 255 : 0) : rb;
        2: src = ((d >> p) & 1) != 0 ? 255 : 0;
        3: begin src = cfgSrValue[p] ? 255 : 0; msk = msk & rb; end
        default: src = lb;
      endcase
      case (int'(cfgAluFunc))
        1: res = src & lb;
        2: res = src | lb;
        3: res = src ^ lb;
        default: res = src;
      endcase
      if (cfgWriteMode == 2'd1) outb = lb;
      else outb = (res & msk) | (lb & ~msk & 255);
      w[p*8 +: 8] = 8'(outb);
    end
    return w;
  endfunction

  function automatic int modelRead(logic [31:0] lat);
    int acc, b;
    if (!cfgReadMode) return int'(lat[int'(cfgReadPlane)*8 +: 8]);
    acc = 0;
    for (int p = 0; p < 4; p++) begin
      b = int'(lat[p*8 +: 8]) ^ (cfgCmpColor[p] ? 255 : 0);
      if (!cfgCmpCare[p]) b = 0;
      acc = acc | b;
    end
    return (~acc) & 255;
  endfunction

  task automatic doRead(input int a, input string tag);
    int exp;
    @(negedge clk);
    check(hostReady === 1'b1, "R12 ready before read", 32'(hostReady), 1);
    hostReq = 1; hostWe = 0; hostAddr = AW'(a);
    @(negedge clk);
    hostReq = 0;
    check(hostReady === 1'b0 && hostRvalid === 1'b0, "R12 fill cycle", {hostReady, hostRvalid}, 0);
    refLatch = refMem[a];
    exp = modelRead(refLatch);
    @(negedge clk);
    check(hostRvalid === 1'b1, "R12 rvalid", 32'(hostRvalid), 1);
    check(hostRdata === 8'(exp), tag, 32'(hostRdata), 32'(exp));
  endtask

  task automatic doWrite(input int a, input int d, input string tag);
    logic [31:0] w;
    @(negedge clk);
    check(hostReady === 1'b1 && hostRvalid === 1'b0, "R12 idle before write", {hostReady, hostRvalid}, 2);
    hostReq = 1; hostWe = 1; hostAddr = AW'(a); hostWdata = 8'(d);
    w = modelWord(refLatch, d);
    for (int p = 0; p < 4; p++)
      if (cfgPlaneMask[p]) refMem[a][p*8 +: 8] = w[p*8 +: 8];
    @(negedge clk);
    hostReq = 0; hostWe = 0;
    check(mem[a] === refMem[a], tag, mem[a], refMem[a]);
  endtask

  task automatic setWrite(input int wm, input int rot, input int alu, input int bm, input int pm);
    cfgWriteMode = 2'(wm); cfgRotate = 3'(rot); cfgAluFunc = 2'(alu);
    cfgBitMask = 8'(bm); cfgPlaneMask = 4'(pm);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) refMem[i] = seedWord(i);
    refLatch = '0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check(hostReady === 1'b1, "R1 ready after reset", 32'(hostReady), 1);
    check(hostRvalid === 1'b0, "R1 rvalid after reset", 32'(hostRvalid), 0);
    check(memWe === 1'b0 && memRe === 1'b0, "R1 memory idle", {memWe, memRe}, 0);

    // R1: latch is zero out of reset
    setWrite(1, 5, 3, 8'h00, 4'hF);
    doWrite(40, 8'hA5, "R1 latch zero copy");

    // R3: each plane in read mode 0
    cfgReadMode = 0;
    for (int p = 0; p < 4; p++) begin
      cfgReadPlane = 2'(p);
      doRead(3, "R3 read plane");
    end

    // R2 and R6: copy word through latch, alu and mask ignored
    doRead(7, "R3 read before copy");
    setWrite(1, 2, 3, 8'h00, 4'hF);
    doWrite(50, 8'h3C, "R6 latch copy ignores alu/mask");
    check(mem[50] === refMem[7], "R2 latch holds read word", mem[50], refMem[7]);

    // R4: compare read
    cfgReadMode = 1;
    setWrite(0, 0, 0, 8'hFF, 4'hF);
    cfgSrEnable = 4'hF; cfgSrValue = 4'b1010;
    doWrite(12, 8'h00, "R5 set/reset all planes");
    cfgCmpColor = 4'b1010; cfgCmpCare = 4'hF;
    doRead(12, "R4 full match 0xFF");
    cfgCmpColor = 4'b0110; cfgCmpCare = 4'b0011;
    doRead(9, "R4 partial care");
    cfgCmpCare = 4'h0;
    doRead(9, "R4 zero care 0xFF");
    cfgReadMode = 0;

    // R5: rotation extremes
    cfgSrEnable = 4'b0000;
    setWrite(0, 0, 0, 8'hFF, 4'hF);
    doWrite(20, 8'h81, "R5 rotate 0");
    setWrite(0, 7, 0, 8'hFF, 4'hF);
    doWrite(21, 8'h81, "R5 rotate 7");
    cfgSrEnable = 4'b0101; cfgSrValue = 4'b0001;
    setWrite(0, 3, 0, 8'hFF, 4'hF);
    doWrite(22, 8'hC6, "R5 partial set/reset");

    // R9: ALU functions with fresh latch
    cfgSrEnable = 4'b0000;
    for (int f = 0; f < 4; f++) begin
      doRead(30 + f, "R3 latch fill for alu");
      setWrite(0, 1, f, 8'hFF, 4'hF);
      doWrite(30 + f, 8'h5B, "R9 alu function");
    end

    // R10: bit mask
    doRead(35, "R3 latch fill for mask");
    setWrite(0, 0, 0, 8'hF0, 4'hF);
    doWrite(35, 8'h00, "R10 partial bit mask");
    setWrite(2, 0, 0, 8'h00, 4'hF);
    doWrite(36, 8'hFF, "R10 zero bit mask");

    // R7 and R8
    doRead(37, "R3 latch fill mode2");
    setWrite(2, 0, 2, 8'h3C, 4'hF);
    doWrite(37, 8'h09, "R7 expand mode");
    cfgSrValue = 4'b1100;
    setWrite(3, 4, 0, 8'hF7, 4'hF);
    doWrite(38, 8'h1E, "R8 set/reset with rotated mask");

    // R11: plane mask
    setWrite(0, 0, 0, 8'hFF, 4'b0110);
    doWrite(39, 8'hEE, "R11 plane mask partial");
    setWrite(0, 0, 0, 8'hFF, 4'b0000);
    doWrite(41, 8'h11, "R11 plane mask none");

    // mixed sequence over all modes
    for (int n = 0; n < 500; n++) begin
      int a;
      a = nextRand() % DEPTH;
      if ((nextRand() & 1) != 0) begin
        cfgReadMode = 1'(nextRand()); cfgReadPlane = 2'(nextRand());
        cfgCmpColor = 4'(nextRand()); cfgCmpCare = 4'(nextRand());
        doRead(a, "R4 mixed read");
      end else begin
        cfgSrValue = 4'(nextRand()); cfgSrEnable = 4'(nextRand());
        setWrite(nextRand() % 4, nextRand() % 8, nextRand() % 4, nextRand() % 256, nextRand() % 16);
        doWrite(a, nextRand() % 256, "R10 mixed write");
      end
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule